// File: doc/BRIEF.md
# Video sync word filter/detector

This block sits directly behind the parallel character input of a serial digital video encoder. Every clock it registers one 10-bit character together with its qualifier and control levels. One clock later it presents the character, with a matching valid strobe, to the scrambler stage that follows. It also raises an active-low flag whenever the registered character belongs to the timing-reference (sync) family.

In video mode the block recognises a sync character by its eight most significant bits alone: they must be all zeros or all ones. When the active-low filter control is asserted, the two low bits of such a character are rewritten to match the upper eight. A source that carries only 8 significant bits therefore still yields exact 10-bit sync words, and the 30-bit sync preamble reaches the scrambler intact.

In packet mode the block passes the character through untouched and never flags it. Mode and filter are sampled with each character, so they may change from one word to the next.

Top module: `sync_word_filter`

## Requirements
- R1: While rst_ni is low, sync_det_no is 1, char_vld_o is 0 and char_o is 0.
- R2: In video mode (mode_i = 0), a valid character with bits [9:2] all 0 or all 1 (0x000 to 0x003, 0x3FC to 0x3FF) drives sync_det_no to 0 in the same cycle that the character appears on char_o.
- R3: In video mode, a valid character whose bits [9:2] are neither all 0 nor all 1 (for example 0x004 or 0x3FB) leaves sync_det_no at 1.
- R4: With filt_en_ni = 0 in video mode, sync characters 0x000 to 0x003 leave as 0x000 and 0x3FC to 0x3FF leave as 0x3FF.
- R5: With filt_en_ni = 1, every valid character appears on char_o unchanged.
- R6: With filt_en_ni = 0, characters that are not sync characters appear on char_o unchanged.
- R7: In packet mode (mode_i = 1), sync_det_no stays 1 and the character appears unchanged, whatever filt_en_ni is.
- R8: A character sampled with char_vld_i = 1 on a rising edge appears on char_o on the next rising edge, and char_vld_o is high for exactly that cycle.
- R9: A run of consecutive sync characters holds sync_det_no low for the whole run. The first valid non-sync character returns it high.
- R10: mode_i and filt_en_ni are sampled on the same edge as the character, and each applies only to that character.
- R11: In a cycle that follows a slot with char_vld_i = 0, char_o keeps its previous value, char_vld_o is 0 and sync_det_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_i | input | 10 | Incoming character |
| char_vld_i | input | 1 | Character qualifier |
| filt_en_ni | input | 1 | Low-bit sync filter enable, active low |
| mode_i | input | 1 | 0 = video mode, 1 = packet mode |
| char_o | output | 10 | Registered, possibly corrected character |
| char_vld_o | output | 1 | Valid strobe aligned with char_o |
| sync_det_no | output | 1 | Sync character flag, active low |

## Verification
The hardest case to produce at the ports is a control change on a word boundary. A sync word taken in video mode with the filter on can sit directly beside the same code taken in packet mode or with the filter off. Only a design that carries mode and filter through its register alongside the data keeps the two treatments apart. The stimulus interleaves such words back to back, and it breaks sync runs with both non-sync characters and empty slots. A scoreboard keyed to the two-edge path then confirms the flag, the data and the strobe of every slot.

// File: rtl/sync_filt_pkg.sv
package sync_filt_pkg;
  localparam int unsigned CHAR_W = 10;
  localparam int unsigned TAG_W  = 8;

  typedef enum logic {
    MODE_VIDEO  = 1'b0,
    MODE_PACKET = 1'b1
  } mode_e;

  typedef struct packed {
    logic  vld;
    logic  filt_n;
    mode_e mode;
  } ctl_t;
endpackage

// File: rtl/sfd_in_stage.sv
module sfd_in_stage
  import sync_filt_pkg::*;
#(
  parameter int unsigned W = CHAR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] char_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] char_q_o,
  output ctl_t         ctl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_q_o <= '0;
      ctl_q_o  <= '{vld: 1'b0, filt_n: 1'b1, mode: MODE_VIDEO};
    end else begin
      char_q_o <= char_i;
      ctl_q_o  <= ctl_i;
    end
  end
endmodule

// File: rtl/sfd_classify.sv
module sfd_classify
  import sync_filt_pkg::*;
#(
  parameter int unsigned W  = CHAR_W,
  parameter int unsigned TW = TAG_W
) (
  input  logic [W-1:0] char_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] char_o,
  output logic         det_n_o
);
  localparam int unsigned LW = W - TW;

  logic [TW-1:0] tag;
  logic          all_zero, all_one, is_sync, rewrite;

  assign tag      = char_i[W-1 -: TW];
  assign all_zero = ~|tag;
  assign all_one  = &tag;
  assign is_sync  = (all_zero | all_one) && (ctl_i.mode == MODE_VIDEO);
  assign rewrite  = is_sync && !ctl_i.filt_n;
  assign det_n_o  = ~(is_sync && ctl_i.vld);

  assign char_o[W-1 -: TW] = tag;

  // low bits follow the tag value when the filter is on
  for (genvar i = 0; i < LW; i++) begin : g_low
    assign char_o[i] = rewrite ? all_one : char_i[i];
  end
endmodule

// File: rtl/sfd_out_stage.sv
module sfd_out_stage #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] char_i,
  input  logic         vld_i,
  input  logic         det_n_i,
  output logic [W-1:0] char_o,
  output logic         vld_o,
  output logic         det_n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_o  <= '0;
      vld_o   <= 1'b0;
      det_n_o <= 1'b1;
    end else begin
      vld_o   <= vld_i;
      det_n_o <= det_n_i;
      if (vld_i) char_o <= char_i;
    end
  end
endmodule

// File: rtl/sync_word_filter.sv
module sync_word_filter
  import sync_filt_pkg::*;
#(
  parameter int unsigned W  = CHAR_W,
  parameter int unsigned TW = TAG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] char_i,
  input  logic         char_vld_i,
  input  logic         filt_en_ni,
  input  logic         mode_i,
  output logic [W-1:0] char_o,
  output logic         char_vld_o,
  output logic         sync_det_no
);
  ctl_t         ctl_in, ctl_q;
  logic [W-1:0] char_q, char_fix;
  logic         det_n;

  assign ctl_in = '{vld: char_vld_i, filt_n: filt_en_ni, mode: mode_e'(mode_i)};

  sfd_in_stage #(.W(W)) in_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .char_i   (char_i),
    .ctl_i    (ctl_in),
    .char_q_o (char_q),
    .ctl_q_o  (ctl_q)
  );

  sfd_classify #(.W(W), .TW(TW)) cls_i (
    .char_i  (char_q),
    .ctl_i   (ctl_q),
    .char_o  (char_fix),
    .det_n_o (det_n)
  );

  sfd_out_stage #(.W(W)) out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .char_i  (char_fix),
    .vld_i   (ctl_q.vld),
    .det_n_i (det_n),
    .char_o  (char_o),
    .vld_o   (char_vld_o),
    .det_n_o (sync_det_no)
  );
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker #(
  parameter int unsigned W  = 10,
  parameter int unsigned TW = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] char_i,
  input logic         char_vld_i,
  input logic         filt_en_ni,
  input logic         mode_i,
  input logic [W-1:0] char_o,
  input logic         char_vld_o,
  input logic         sync_det_no
);
  logic [1:0]    age;
  logic [TW-1:0] tag_in;
  logic          sync_in;

  assign tag_in  = char_i[W-1 -: TW];
  assign sync_in = (tag_in == '0) || (tag_in == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (char_vld_o == $past(char_vld_i, 2)));

  p_det_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && $past(char_vld_i, 2) && !$past(mode_i, 2) && $past(sync_in, 2)
    |-> !sync_det_no);

  p_nodet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && !$past(sync_in, 2) |-> sync_det_no);

  p_pkt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && $past(mode_i, 2) |-> sync_det_no);

  p_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && char_vld_o && !sync_det_no && !$past(filt_en_ni, 2)
    |-> (char_o == '0 || char_o == '1));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && char_vld_o && $past(filt_en_ni, 2)
    |-> (char_o == $past(char_i, 2)));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) && !$past(char_vld_i, 2) |-> ($stable(char_o) && sync_det_no));
endmodule

bind sync_word_filter sfd_checker #(.W(W), .TW(TW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .char_i      (char_i),
  .char_vld_i  (char_vld_i),
  .filt_en_ni  (filt_en_ni),
  .mode_i      (mode_i),
  .char_o      (char_o),
  .char_vld_o  (char_vld_o),
  .sync_det_no (sync_det_no)
);

// File: tb/sync_word_filter_tb_top.sv
module sync_word_filter_tb_top;
  typedef struct {
    logic [9:0] ch;
    logic       vld;
    logic       det_n;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] char_i = '0;
  logic       char_vld_i = 1'b0;
  logic       filt_en_ni = 1'b1;
  logic       mode_i = 1'b0;
  logic [9:0] char_o;
  logic       char_vld_o, sync_det_no;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic [9:0] last_out = '0;
  exp_t q[$];

  always #4 clk = ~clk;

  sync_word_filter dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .char_i      (char_i),
    .char_vld_i  (char_vld_i),
    .filt_en_ni  (filt_en_ni),
    .mode_i      (mode_i),
    .char_o      (char_o),
    .char_vld_o  (char_vld_o),
    .sync_det_no (sync_det_no)
  );

  task automatic chk(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] c, input logic v, input logic f_n, input logic m, input string req);
    exp_t e;
    logic sync;
    @(negedge clk);
    char_i = c; char_vld_i = v; filt_en_ni = f_n; mode_i = m;
    sync = (c[9:2] == 8'h00) || (c[9:2] == 8'hFF);
    e.req = req;
    e.vld = v;
    if (!v) begin
      e.det_n = 1'b1;
      e.ch = last_out;
    end else if (m) begin
      e.det_n = 1'b1;
      e.ch = c;
    end else begin
      e.det_n = !sync;
      e.ch = (sync && !f_n) ? (c[9] ? 10'h3FF : 10'h000) : c;
    end
    last_out = e.ch;
    q.push_back(e);
  endtask

  // monitor: entry pushed two cycles earlier is due now
  always @(posedge clk) begin
    #2;
    if (rst_ni && q.size() >= 2) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "char_vld_o", {9'd0, char_vld_o}, {9'd0, e.vld});
      chk(e.req, "sync_det_no", {9'd0, sync_det_no}, {9'd0, e.det_n});
      chk(e.req, "char_o", char_o, e.ch);
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with active-looking inputs
    repeat (2) @(negedge clk);
    char_i = 10'h3FD; char_vld_i = 1'b1; filt_en_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sync_det_no", {9'd0, sync_det_no}, 10'd1);
    chk("R1", "char_vld_o", {9'd0, char_vld_o}, 10'd0);
    chk("R1", "char_o", char_o, 10'h000);
    char_vld_i = 1'b0; filt_en_ni = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 R5 all sync codes, filter off, back to back (R9 run)
    for (int i = 0; i < 4; i++) drive(10'(i), 1'b1, 1'b1, 1'b0, "R2_R5");
    for (int i = 0; i < 4; i++) drive(10'h3FC + 10'(i), 1'b1, 1'b1, 1'b0, "R2_R9");
    // R9 run ends on first non-sync
    drive(10'h004, 1'b1, 1'b1, 1'b0, "R9");
    // R4 filter on
    for (int i = 0; i < 4; i++) drive(10'(i), 1'b1, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 4; i++) drive(10'h3FC + 10'(i), 1'b1, 1'b0, 1'b0, "R4");
    // R3 R6 non-sync with filter on
    drive(10'h004, 1'b1, 1'b0, 1'b0, "R3_R6");
    drive(10'h3FB, 1'b1, 1'b0, 1'b0, "R3_R6");
    drive(10'h201, 1'b1, 1'b0, 1'b0, "R3_R6");
    drive(10'h1FE, 1'b1, 1'b0, 1'b0, "R3_R6");
    // R7 packet mode
    drive(10'h3FD, 1'b1, 1'b0, 1'b1, "R7");
    drive(10'h002, 1'b1, 1'b0, 1'b1, "R7");
    drive(10'h001, 1'b1, 1'b1, 1'b1, "R7");
    // R10 per-word control changes
    drive(10'h002, 1'b1, 1'b0, 1'b0, "R10");
    drive(10'h002, 1'b1, 1'b0, 1'b1, "R10");
    drive(10'h3FE, 1'b1, 1'b1, 1'b0, "R10");
    drive(10'h3FE, 1'b1, 1'b0, 1'b0, "R10");
    drive(10'h001, 1'b1, 1'b0, 1'b1, "R10");
    drive(10'h001, 1'b1, 1'b0, 1'b0, "R10");
    // R11 empty slots hold data, even with sync code on char_i
    drive(10'h3FD, 1'b1, 1'b0, 1'b0, "R11");
    drive(10'h000, 1'b0, 1'b0, 1'b0, "R11");
    drive(10'h155, 1'b0, 1'b1, 1'b0, "R11");
    drive(10'h3FF, 1'b1, 1'b1, 1'b0, "R8");
    drive(10'h3FF, 1'b0, 1'b1, 1'b0, "R8");
    drive(10'h2AA, 1'b1, 1'b1, 1'b0, "R8");
    // sweep of non-sync values
    for (int i = 0; i < 32; i++) drive(10'(i * 31 + 4), 1'b1, 1'(i % 2), 1'b0, "R3");
    repeat (3) drive(10'h000, 1'b0, 1'b1, 1'b0, "R11");
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule